// File: doc/BRIEF.md
# Zoned TLB Translation Lookup

This block performs the search step of a fully associative, software-managed translation lookaside buffer. A request presents a virtual address, an access kind (read, write or instruction fetch) and a privilege flag (user or supervisor). The block compares the request against every stored entry in parallel. Each entry has its own page size, from 1 KB to 16 MB. It can be tied to a process through an 8-bit translation ID. A 2-bit protection code, taken per zone from a shared zone register, can hide the entry from user code or widen its rights.

The entry storage, the current process ID and the zone register are plain inputs, owned by the surrounding logic. One clock after a request the block reports one of three outcomes: a miss, a protection fault, or a hit. A hit carries the physical page number, the page size code and the index of the entry. A fault carries the index of the entry that caused it. Loading entries and handling misses or faults are left to the surrounding logic.

Top module: `zoned_tlb_lookup`

## Requirements
- R1: The page size comes from tag bits [9:7]. Code c gives a page of 1 KB × 4^c, so code 0 is 1 KB and code 7 is 16 MB. An entry's address matches when the virtual address and tag bits [31:10] agree on every bit at or above bit 10+2c.
- R2: Tag bit 6 is the valid bit, and entries with it clear never match. With no matching entry the result is a miss: code 2'b00, hit low, and page number, size and index all zero.
- R3: A translation ID of zero matches any process. A nonzero ID matches only when it equals `cur_pid`.
- R4: When several entries qualify, the lowest index decides the outcome and later entries are not considered.
- R5: Data bits [7:4] select zone z. Its 2-bit code is `zone_prot[31-2z:30-2z]`. Under code 1 the entry's own rights apply: data bit 8 grants write and data bit 9 grants execute.
- R6: Under zone code 0 the entry is skipped for user requests, and the search moves on to later entries. Supervisor requests use the entry's own rights.
- R7: Zone code 2 grants write and execute to supervisor requests only, with user requests keeping the entry's own rights. Zone code 3 grants write and execute to both.
- R8: A zone number above the parameter `ZONE_MAX`, or any zone when `ZONES_EN` is 0, is treated as code 1, whatever the zone register holds.
- R9: Access kind 2'b00 is read, 2'b01 is write, 2'b10 is fetch, and 2'b11 is handled as read. A read never faults. A write without write rights, or a fetch without execute rights, gives code 2'b01 with the entry's index, and the search ends there.
- R10: A hit gives code 2'b10 with `rsp_hit` high. It also reports data bits [31:10] as the page number, the entry's size code and its index. `rsp_hit` is high exactly when the code is 2'b10, and code 2'b11 never appears.
- R11: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and the outcome belongs to that request.
- R12: While reset is asserted, `rsp_valid`, `rsp_hit` and `rsp_code` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | ADDR_W | Virtual address to translate |
| req_kind | input | 2 | Access kind: read, write or fetch |
| req_user | input | 1 | High for a user-mode request |
| cur_pid | input | 8 | Current process ID |
| zone_prot | input | 32 | Sixteen 2-bit zone protection codes |
| tag_words | input | ENTRIES*ADDR_W | Tag word of every entry, entry 0 lowest |
| data_words | input | ENTRIES*ADDR_W | Data word of every entry, entry 0 lowest |
| tid_words | input | ENTRIES*8 | Translation ID of every entry |
| rsp_valid | output | 1 | Outcome present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_code | output | 2 | 00 miss, 01 protection fault, 10 hit |
| rsp_ppn | output | ADDR_W-10 | Physical page number on a hit |
| rsp_size | output | 3 | Page size code on a hit |
| rsp_index | output | $clog2(ENTRIES) | Index of the deciding entry |

## Verification
The assertions assume three things about the inputs. `req_valid` is low while reset is asserted. The entry words, PID and zone register are stable around the clock edge that samples a request. `req_kind` is one of its four defined codes. The stimulus changes entries, PID and zone codes only at falling edges. It keeps one idle cycle after every request before touching any of them, so each outcome depends only on the state presented with its request. The zone register starts with every zone at code 1, and single fields are changed only for the zone cases.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int PAGE_LSB      = 10;
    localparam int TAG_VALID_BIT = 6;
    localparam int SIZE_LSB      = 7;
    localparam int SIZE_W        = 3;
    localparam int DATA_WR_BIT   = 8;
    localparam int DATA_EX_BIT   = 9;
    localparam int ZONE_LSB      = 4;
    localparam int ZONE_W        = 4;
    localparam int TID_W         = 8;
    localparam int ZREG_W        = 32;

    typedef enum logic [1:0] {
        RES_MISS  = 2'b00,
        RES_FAULT = 2'b01,
        RES_HIT   = 2'b10
    } res_code_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    // Zone z owns bits [31-2z:30-2z] of the zone register.
    function automatic logic [1:0] zone_field(input logic [ZREG_W-1:0] zreg,
                                              input logic [ZONE_W-1:0] zone);
        int sh;
        sh = 30 - 2 * int'(zone);
        return zreg[sh +: 2];
    endfunction
endpackage

// File: rtl/tlb_entry_eval.sv
module tlb_entry_eval
    import tlb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ZONE_MAX = 11,
    parameter bit ZONES_EN = 1'b1
) (
    input  logic [ADDR_W-1:0] tag_word,
    input  logic [ADDR_W-1:0] data_word,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [TID_W-1:0]  tid,
    input  logic [TID_W-1:0]  pid,
    input  logic [1:0]        kind,
    input  logic              user,
    input  logic [ZREG_W-1:0] zone_reg,
    output logic              candidate,
    output logic              permitted
);
    localparam int PN_W = ADDR_W - PAGE_LSB;

    logic [SIZE_W-1:0] size_code;
    logic [PN_W-1:0]   span_mask;
    logic [ZONE_W-1:0] zone;
    logic [1:0]        zcode;
    logic              addr_eq, tid_ok, hidden, can_wr, can_ex;
    logic              unused_bits;

    assign unused_bits = ^{tag_word[TAG_VALID_BIT-1:0], data_word[ZONE_LSB-1:0],
                           vaddr[PAGE_LSB-1:0]};

    always_comb begin
        size_code = tag_word[SIZE_LSB +: SIZE_W];
        span_mask = ~((PN_W'(1) << {size_code, 1'b0}) - PN_W'(1));
        addr_eq   = ((vaddr[ADDR_W-1:PAGE_LSB] ^ tag_word[ADDR_W-1:PAGE_LSB])
                     & span_mask) == '0;
        tid_ok    = (tid == '0) || (tid == pid);

        zone = data_word[ZONE_LSB +: ZONE_W];
        if (!ZONES_EN || (int'(zone) > ZONE_MAX))
            zcode = 2'd1;
        else
            zcode = zone_field(zone_reg, zone);

        can_wr = data_word[DATA_WR_BIT];
        can_ex = data_word[DATA_EX_BIT];
        hidden = 1'b0;
        case (zcode)
            2'd0: hidden = user;
            2'd2: if (!user) begin
                      can_wr = 1'b1;
                      can_ex = 1'b1;
                  end
            2'd3: begin
                      can_wr = 1'b1;
                      can_ex = 1'b1;
                  end
            default: ;
        endcase

        candidate = tag_word[TAG_VALID_BIT] && addr_eq && tid_ok && !hidden;
        case (acc_kind_e'(kind))
            ACC_WRITE: permitted = can_wr;
            ACC_FETCH: permitted = can_ex;
            default:   permitted = 1'b1;
        endcase
    end
endmodule

// File: rtl/tlb_first_sel.sv
module tlb_first_sel #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/zoned_tlb_lookup.sv
module zoned_tlb_lookup
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int ADDR_W   = 32,
    parameter int ZONE_MAX = 11,
    parameter bit ZONES_EN = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_vaddr,
    input  logic [1:0]                    req_kind,
    input  logic                          req_user,
    input  logic [7:0]                    cur_pid,
    input  logic [31:0]                   zone_prot,
    input  logic [ENTRIES*ADDR_W-1:0]     tag_words,
    input  logic [ENTRIES*ADDR_W-1:0]     data_words,
    input  logic [ENTRIES*8-1:0]          tid_words,
    output logic                          rsp_valid,
    output logic                          rsp_hit,
    output logic [1:0]                    rsp_code,
    output logic [ADDR_W-11:0]            rsp_ppn,
    output logic [2:0]                    rsp_size,
    output logic [$clog2(ENTRIES)-1:0]    rsp_index
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int PN_W  = ADDR_W - PAGE_LSB;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [1:0]        code;
        logic [PN_W-1:0]   ppn;
        logic [SIZE_W-1:0] size;
        logic [IDX_W-1:0]  idx;
    } rsp_t;

    logic [ENTRIES-1:0] cand;
    logic [ENTRIES-1:0] allow;
    logic               any_cand;
    logic [IDX_W-1:0]   first_idx;
    rsp_t               rsp_d, rsp_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        tlb_entry_eval #(
            .ADDR_W  (ADDR_W),
            .ZONE_MAX(ZONE_MAX),
            .ZONES_EN(ZONES_EN)
        ) u_eval (
            .tag_word (tag_words[e*ADDR_W +: ADDR_W]),
            .data_word(data_words[e*ADDR_W +: ADDR_W]),
            .vaddr    (req_vaddr),
            .tid      (tid_words[e*TID_W +: TID_W]),
            .pid      (cur_pid),
            .kind     (req_kind),
            .user     (req_user),
            .zone_reg (zone_prot),
            .candidate(cand[e]),
            .permitted(allow[e])
        );
    end

    tlb_first_sel #(
        .N    (ENTRIES),
        .IDX_W(IDX_W)
    ) u_first (
        .req  (cand),
        .found(any_cand),
        .idx  (first_idx)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.hit  = 1'b0;
            rsp_d.code = RES_MISS;
            rsp_d.ppn  = '0;
            rsp_d.size = '0;
            rsp_d.idx  = '0;
            if (any_cand) begin
                rsp_d.idx = first_idx;
                if (allow[first_idx]) begin
                    rsp_d.hit  = 1'b1;
                    rsp_d.code = RES_HIT;
                    rsp_d.ppn  = data_words[int'(first_idx)*ADDR_W + PAGE_LSB +: PN_W];
                    rsp_d.size = tag_words[int'(first_idx)*ADDR_W + SIZE_LSB +: SIZE_W];
                end else begin
                    rsp_d.code = RES_FAULT;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_code  = rsp_q.code;
    assign rsp_ppn   = rsp_q.ppn;
    assign rsp_size  = rsp_q.size;
    assign rsp_index = rsp_q.idx;
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic [1:0]                 req_kind,
    input logic [ENTRIES*ADDR_W-1:0]  tag_words,
    input logic                       rsp_valid,
    input logic                       rsp_hit,
    input logic [1:0]                 rsp_code,
    input logic [ADDR_W-11:0]         rsp_ppn,
    input logic [2:0]                 rsp_size,
    input logic [$clog2(ENTRIES)-1:0] rsp_index
);
    logic [ENTRIES*ADDR_W-1:0] prev_tag_q;

    always_ff @(posedge clk) prev_tag_q <= tag_words;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R11
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R11
    AST_HIT_FLAG_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit == (rsp_code == RES_HIT))); // R10
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code != 2'b11)); // R10
    AST_MISS_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RES_MISS) |->
            (rsp_ppn == '0 && rsp_size == '0 && rsp_index == '0)); // R2
    AST_DECIDER_WAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != RES_MISS) |->
            prev_tag_q[int'(rsp_index)*ADDR_W + TAG_VALID_BIT]); // R2
    AST_READ_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == ACC_READ) |=> (rsp_code != RES_FAULT)); // R9
endmodule

bind zoned_tlb_lookup tlb_lookup_chk #(
    .ENTRIES(ENTRIES),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .tag_words(tag_words),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_code (rsp_code),
    .rsp_ppn  (rsp_ppn),
    .rsp_size (rsp_size),
    .rsp_index(rsp_index)
);

// File: tb/zoned_tlb_lookup_test.sv
module zoned_tlb_lookup_test;
    localparam int N    = 64;
    localparam int AW   = 32;
    localparam int ZMAX = 11;

    typedef struct {
        logic [1:0]  code;
        logic        hit;
        logic [21:0] ppn;
        logic [2:0]  size;
        logic [5:0]  idx;
        string       rq;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_vaddr = '0;
    logic [1:0]      req_kind = '0;
    logic            req_user = 1'b0;
    logic [7:0]      cur_pid = '0;
    logic [31:0]     zone_val = 32'h5555_5555;
    logic [N*AW-1:0] tag_flat = '0;
    logic [N*AW-1:0] data_flat = '0;
    logic [N*8-1:0]  tid_flat = '0;
    logic            rsp_valid, rsp_hit;
    logic [1:0]      rsp_code;
    logic [21:0]     rsp_ppn;
    logic [2:0]      rsp_size;
    logic [5:0]      rsp_index;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    exp_t mon_e;

    always #5 clk = ~clk;

    zoned_tlb_lookup uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .cur_pid(cur_pid),
        .zone_prot(zone_val), .tag_words(tag_flat), .data_words(data_flat),
        .tid_words(tid_flat), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_code(rsp_code), .rsp_ppn(rsp_ppn), .rsp_size(rsp_size),
        .rsp_index(rsp_index)
    );

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] kind,
                                   input logic user, input string rq);
        exp_t r;
        r.code = 2'b00; r.hit = 1'b0; r.ppn = '0; r.size = '0; r.idx = '0; r.rq = rq;
        for (int i = 0; i < N; i++) begin
            logic [31:0] t, d;
            logic [7:0]  id;
            longint unsigned bytes;
            int   z;
            logic [1:0] zc;
            bit   wr, ex;
            t = tag_flat[i*32 +: 32];
            d = data_flat[i*32 +: 32];
            id = tid_flat[i*8 +: 8];
            if (!t[6]) continue;
            bytes = 64'd1024 << (2 * int'(t[9:7]));
            if ((longint'(va) / bytes) != (longint'({t[31:10], 10'b0}) / bytes)) continue;
            if (id != 8'd0 && id != cur_pid) continue;
            z  = int'(d[7:4]);
            zc = (z > ZMAX) ? 2'd1 : zone_val[31-2*z -: 2];
            wr = d[8];
            ex = d[9];
            if (zc == 2'd0 && user) continue;
            if (zc == 2'd3 || (zc == 2'd2 && !user)) begin wr = 1'b1; ex = 1'b1; end
            r.idx = 6'(i);
            if ((kind == 2'b01 && !wr) || (kind == 2'b10 && !ex)) r.code = 2'b01;
            else begin
                r.code = 2'b10; r.hit = 1'b1; r.ppn = d[31:10]; r.size = t[9:7];
            end
            break;
        end
        return r;
    endfunction

    task automatic put(input int i, input logic [31:0] epn, input logic [2:0] sz,
                       input logic [7:0] id, input logic [31:0] rpn, input bit wr,
                       input bit ex, input logic [3:0] z, input bit v = 1'b1);
        tag_flat[i*32 +: 32]  = {epn[31:10], sz, v, 6'b0};
        data_flat[i*32 +: 32] = {rpn[31:10], ex, wr, z, 4'b0};
        tid_flat[i*8 +: 8]    = id;
    endtask

    task automatic clear_all();
        tag_flat = '0; data_flat = '0; tid_flat = '0;
    endtask

    task automatic set_zone(input int z, input logic [1:0] c);
        zone_val[31-2*z -: 2] = c;
    endtask

    task automatic issue(input logic [31:0] va, input logic [1:0] k, input logic u,
                         input string rq);
        @(negedge clk);
        req_vaddr = va; req_kind = k; req_user = u; req_valid = 1'b1;
        sb_q.push_back(model(va, k, u, rq));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R11 unexpected response: actual rsp_valid=1 expected 0");
            end else begin
                mon_e = sb_q.pop_front();
                if (rsp_code !== mon_e.code || rsp_hit !== mon_e.hit || rsp_ppn !== mon_e.ppn
                    || rsp_size !== mon_e.size || rsp_index !== mon_e.idx) begin
                    fails++;
                    $display("FAIL %s: actual code=%0d hit=%0d ppn=%h size=%0d idx=%0d expected code=%0d hit=%0d ppn=%h size=%0d idx=%0d",
                             mon_e.rq, rsp_code, rsp_hit, rsp_ppn, rsp_size, rsp_index,
                             mon_e.code, mon_e.hit, mon_e.ppn, mon_e.size, mon_e.idx);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R11 watchdog: actual run still busy, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_code !== 2'b00) begin
            fails++;
            $display("FAIL R12 reset: actual valid=%0d hit=%0d code=%0d expected 0 0 0",
                     rsp_valid, rsp_hit, rsp_code);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Empty array
        issue(32'h1234_5000, 2'b00, 1'b0, "R2 empty miss");

        // Basic 4K page, global ID
        put(5, 32'h0001_2000, 3'd1, 8'h00, 32'h8765_4000, 1'b0, 1'b0, 4'd0);
        issue(32'h0001_2ABC, 2'b00, 1'b0, "R10 4K read hit");
        issue(32'h0001_2FFF, 2'b00, 1'b1, "R1 4K last byte");
        issue(32'h0001_3000, 2'b00, 1'b0, "R1 4K next page miss");

        // 16M and 1K pages
        put(10, 32'h0100_0000, 3'd7, 8'h00, 32'h4000_0000, 1'b1, 1'b1, 4'd0);
        issue(32'h01FF_FFFC, 2'b00, 1'b0, "R1 16M top hit");
        issue(32'h0200_0000, 2'b00, 1'b0, "R1 16M beyond miss");
        put(11, 32'h0002_0400, 3'd0, 8'h00, 32'h0000_0C00, 1'b1, 1'b0, 4'd0);
        issue(32'h0002_07FF, 2'b01, 1'b0, "R1 1K write hit");
        issue(32'h0002_0800, 2'b00, 1'b0, "R1 1K beyond miss");

        // Entry with valid bit clear
        put(12, 32'h0003_0000, 3'd1, 8'h00, 32'h0000_1000, 1'b1, 1'b1, 4'd0, 1'b0);
        issue(32'h0003_0010, 2'b00, 1'b0, "R2 invalid entry miss");

        // Translation ID
        put(13, 32'h0004_0000, 3'd1, 8'h22, 32'h0000_2000, 1'b1, 1'b1, 4'd0);
        cur_pid = 8'h22;
        issue(32'h0004_0004, 2'b00, 1'b0, "R3 tid equal hit");
        cur_pid = 8'h23;
        issue(32'h0004_0004, 2'b00, 1'b0, "R3 tid differs miss");
        issue(32'h0001_2004, 2'b00, 1'b0, "R3 tid zero global hit");

        // Priority and early fault
        clear_all();
        put(9, 32'h0005_0000, 3'd1, 8'h00, 32'h0009_0000, 1'b1, 1'b1, 4'd0);
        put(3, 32'h0005_0000, 3'd1, 8'h00, 32'h0003_0000, 1'b0, 1'b0, 4'd0);
        put(2, 32'h0005_0000, 3'd1, 8'h77, 32'h0002_0000, 1'b1, 1'b1, 4'd0);
        issue(32'h0005_0100, 2'b00, 1'b0, "R4 lowest index wins");
        issue(32'h0005_0100, 2'b01, 1'b0, "R9 write fault stops search");
        issue(32'h0005_0100, 2'b10, 1'b1, "R9 fetch fault");
        issue(32'h0005_0100, 2'b11, 1'b0, "R9 kind 3 as read");
        put(3, 32'h0005_0000, 3'd1, 8'h00, 32'h0003_0000, 1'b1, 1'b1, 4'd0);
        issue(32'h0005_0100, 2'b10, 1'b0, "R5 own execute hit");
        issue(32'h0005_0100, 2'b01, 1'b1, "R5 own write hit");

        // Zone code 0 hides from user
        clear_all();
        set_zone(1, 2'd0);
        put(2, 32'h0006_0000, 3'd1, 8'h00, 32'h0006_0000, 1'b1, 1'b1, 4'd1);
        put(7, 32'h0006_0000, 3'd1, 8'h00, 32'h0007_0000, 1'b1, 1'b1, 4'd2);
        issue(32'h0006_0040, 2'b00, 1'b1, "R6 user skips zone 0");
        issue(32'h0006_0040, 2'b01, 1'b0, "R6 supervisor own rights");

        // Zone codes 2 and 3
        set_zone(3, 2'd2);
        set_zone(4, 2'd3);
        put(4, 32'h0007_0000, 3'd1, 8'h00, 32'h0017_0000, 1'b0, 1'b0, 4'd3);
        issue(32'h0007_0008, 2'b01, 1'b0, "R7 code 2 supervisor write");
        issue(32'h0007_0008, 2'b01, 1'b1, "R7 code 2 user write fault");
        issue(32'h0007_0008, 2'b10, 1'b0, "R7 code 2 supervisor fetch");
        put(6, 32'h0008_0000, 3'd1, 8'h00, 32'h0018_0000, 1'b0, 1'b0, 4'd4);
        issue(32'h0008_0008, 2'b01, 1'b1, "R7 code 3 user write");
        issue(32'h0008_0008, 2'b10, 1'b1, "R7 code 3 user fetch");

        // Zone number beyond the configured maximum
        set_zone(12, 2'd0);
        set_zone(11, 2'd0);
        put(8, 32'h0009_0000, 3'd1, 8'h00, 32'h0019_0000, 1'b0, 1'b0, 4'd12);
        issue(32'h0009_0000, 2'b00, 1'b1, "R8 zone above max user read");
        issue(32'h0009_0000, 2'b01, 1'b1, "R8 zone above max own rights");
        put(14, 32'h000A_0000, 3'd1, 8'h00, 32'h001A_0000, 1'b1, 1'b1, 4'd11);
        issue(32'h000A_0000, 2'b00, 1'b1, "R8 zone at max applies");

        repeat (4) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || sb_q.size() != 0) begin
            fails++;
            $display("FAIL R11 idle: actual valid=%0d pending=%0d expected 0 0",
                     rsp_valid, sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule